// File: doc/BRIEF.md
# Hall Six-Step Commutation Generator

This block turns a 3-bit rotor position code and a rotation direction bit into the six gate commands of a three-phase bridge. The high-side commands are `gate_hi[0..2]` for phases U, V and W. The low-side commands are `gate_lo[0..2]` for X, Y and Z. In every valid position, one phase is modulated. Its high side follows the PWM level, its own low side follows the inverted PWM level, one other low side is held on, and every remaining switch is off. The PWM level is 1 while the external carrier count is below an 11-bit duty. The duty is built from an 8-bit high part and a 3-bit low part.

The position code comes from one of two places, chosen by a control bit: the live Hall input pins or a software override code. The switch pattern comes from one of two tables:
- a fixed six-step table that depends on the direction bit;
- an eight-entry table that software loads through a write port.

The chosen pattern is captured only when the carrier period-end strobe is high, so a Hall edge cannot cut a pulse short. The six gate commands are registered. The carrier counter and dead-time insertion belong to neighbouring blocks.

Top module: `hall_commutator`

## Requirements
- R1: Position codes 000 and 111 are invalid. When one of them is captured, all six gates are 0, whatever the direction bit and the table select.
- R2: With the fixed table and `dir`=1, the codes map as follows. Each entry reads: modulated phase, then the low side held on.
  - 001: U, Y
  - 011: W, Y
  - 010: W, X
  - 110: V, X
  - 100: V, Z
  - 101: U, Z
- R3: With the fixed table and `dir`=0, the codes map as follows. Each entry reads: modulated phase, then the low side held on.
  - 101: W, X
  - 100: W, Y
  - 110: U, Y
  - 010: U, Z
  - 011: V, Z
  - 001: V, X
- R4: The PWM level is 1 when `carrier` < {`duty_hi`,`duty_lo`}, compared unsigned over 11 bits. It is 0 when the two are equal. The modulated high side carries this level and its own low side carries the exact inverse. The gate outputs follow a carrier change one clock later, with no period end needed.
- R5: The pattern changes only on a clock edge where `period_end` is 1. A position code change at any other time leaves the switch pattern unchanged.
- R6: When `hall_ovr_en` is 1, `hall_ovr` selects the pattern. When it is 0, `hall_in` selects it.
- R7: When `use_user_tbl` is 1, the pattern is the user entry addressed by the selected position code, and `dir` is ignored. An entry holds six 2-bit switch codes:
  - bits [1:0] U, [3:2] V, [5:4] W, [7:6] X, [9:8] Y, [11:10] Z;
  - code 00 = off, 01 = on, 10 = PWM, 11 = inverted PWM.
- R8: A user entry is written on a clock edge where `tbl_we` is 1, at address `tbl_addr` with data `tbl_wdata`. With `tbl_we` at 0, the entry is unchanged.
- R9: Synchronous reset drives all six gates to 0 on the next clock and clears the captured pattern, so the gates stay 0 until the first period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Live rotor position code |
| hall_ovr | input | 3 | Software override position code |
| hall_ovr_en | input | 1 | 1 selects the override code |
| dir | input | 1 | Rotation direction for the fixed table |
| use_user_tbl | input | 1 | 1 selects the user table |
| duty_hi | input | 8 | Upper bits of the 11-bit duty |
| duty_lo | input | 3 | Lower bits of the 11-bit duty |
| carrier | input | 11 | Carrier count from the counter block |
| period_end | input | 1 | Carrier period boundary strobe |
| tbl_we | input | 1 | User table write enable |
| tbl_addr | input | 3 | User table write address |
| tbl_wdata | input | 12 | User table write data |
| gate_hi | output | 3 | High-side gates, bit 0 = U, 1 = V, 2 = W |
| gate_lo | output | 3 | Low-side gates, bit 0 = X, 1 = Y, 2 = Z |

## Verification
The assertions check four things on every cycle:
- reset clears the gates;
- the captured pattern holds still between period ends;
- an invalid code captures an all-off pattern;
- with the fixed table, at most one high side is on and no phase has both switches on.

The exact phase and low side chosen for each code and direction, the PWM compare edge at equal values, the duty assembly, the source selection and the user table contents can only be shown by the bench's scenarios. The bench compares the gate outputs with values computed from the requirements.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int HALL_W  = 3;
  localparam int NUM_PH  = 3;
  localparam int NUM_SW  = 2 * NUM_PH;
  localparam int CODE_W  = 2;
  localparam int PAT_W   = NUM_SW * CODE_W;
  localparam int ENTRIES = 1 << HALL_W;

  typedef enum logic [CODE_W-1:0] {
    SW_OFF = 2'b00,
    SW_ON  = 2'b01,
    SW_PWM = 2'b10,
    SW_INV = 2'b11
  } sw_code_e;

  typedef logic [PAT_W-1:0] pat_t;

  // Pattern: phase ph modulated (high PWM, own low inverted), low side `on` held on.
  function automatic pat_t make_pat(input int ph, input int on);
    pat_t p;
    p = '0;
    p[ph*CODE_W +: CODE_W]            = SW_PWM;
    p[(NUM_PH+ph)*CODE_W +: CODE_W]   = SW_INV;
    p[(NUM_PH+on)*CODE_W +: CODE_W]   = SW_ON;
    return p;
  endfunction
endpackage

// File: rtl/hc_default_table.sv
module hc_default_table
  import hc_pkg::*;
(
  input  logic              dir,
  input  logic [HALL_W-1:0] hall,
  output pat_t              pat
);
  always_comb begin
    case ({dir, hall})
      4'b1_001: pat = make_pat(0, 1);
      4'b1_011: pat = make_pat(2, 1);
      4'b1_010: pat = make_pat(2, 0);
      4'b1_110: pat = make_pat(1, 0);
      4'b1_100: pat = make_pat(1, 2);
      4'b1_101: pat = make_pat(0, 2);
      4'b0_101: pat = make_pat(2, 0);
      4'b0_100: pat = make_pat(2, 1);
      4'b0_110: pat = make_pat(0, 1);
      4'b0_010: pat = make_pat(0, 2);
      4'b0_011: pat = make_pat(1, 2);
      4'b0_001: pat = make_pat(1, 0);
      default:  pat = '0;
    endcase
  end
endmodule

// File: rtl/hc_user_table.sv
module hc_user_table #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  // Small distributed RAM: synchronous write, asynchronous read.
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hc_pattern_sel.sv
module hc_pattern_sel
  import hc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              period_end,
  input  logic [HALL_W-1:0] hall_in,
  input  logic [HALL_W-1:0] hall_ovr,
  input  logic              hall_ovr_en,
  input  logic              use_user_tbl,
  input  pat_t              dflt_pat,
  input  pat_t              user_pat,
  output logic [HALL_W-1:0] sel_hall,
  output pat_t              pat_q
);
  logic code_ok;
  pat_t pat_nxt;

  assign sel_hall = hall_ovr_en ? hall_ovr : hall_in;
  assign code_ok  = (sel_hall != '0) && (sel_hall != '1);

  always_comb begin
    if (!code_ok)          pat_nxt = '0;
    else if (use_user_tbl) pat_nxt = user_pat;
    else                   pat_nxt = dflt_pat;
  end

  always_ff @(posedge clk) begin
    if (rst)             pat_q <= '0;
    else if (period_end) pat_q <= pat_nxt;
  end
endmodule

// File: rtl/hc_gate_drive.sv
module hc_gate_drive
  import hc_pkg::*;
#(
  parameter int DUTY_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  pat_t              pat,
  input  logic [DUTY_W-1:0] carrier,
  input  logic [DUTY_W-1:0] duty,
  output logic [NUM_SW-1:0] gate_q
);
  logic              pwm;
  logic [NUM_SW-1:0] gate_nxt;

  assign pwm = carrier < duty;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    always_comb begin
      case (sw_code_e'(pat[i*CODE_W +: CODE_W]))
        SW_ON:   gate_nxt[i] = 1'b1;
        SW_PWM:  gate_nxt[i] = pwm;
        SW_INV:  gate_nxt[i] = ~pwm;
        default: gate_nxt[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= '0;
    else     gate_q <= gate_nxt;
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
#(
  parameter int DUTY_W    = 11,
  parameter int DUTY_HI_W = 8,
  localparam int DUTY_LO_W = DUTY_W - DUTY_HI_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HALL_W-1:0]    hall_in,
  input  logic [HALL_W-1:0]    hall_ovr,
  input  logic                 hall_ovr_en,
  input  logic                 dir,
  input  logic                 use_user_tbl,
  input  logic [DUTY_HI_W-1:0] duty_hi,
  input  logic [DUTY_LO_W-1:0] duty_lo,
  input  logic [DUTY_W-1:0]    carrier,
  input  logic                 period_end,
  input  logic                 tbl_we,
  input  logic [HALL_W-1:0]    tbl_addr,
  input  logic [PAT_W-1:0]     tbl_wdata,
  output logic [NUM_PH-1:0]    gate_hi,
  output logic [NUM_PH-1:0]    gate_lo
);
  logic [HALL_W-1:0] sel_hall;
  pat_t              dflt_pat;
  pat_t              user_pat;
  pat_t              pat_q;
  logic [NUM_SW-1:0] gate_q;
  logic [DUTY_W-1:0] duty;

  assign duty = {duty_hi, duty_lo};

  hc_default_table u_dflt (
    .dir  (dir),
    .hall (sel_hall),
    .pat  (dflt_pat)
  );

  hc_user_table #(.DEPTH(ENTRIES), .WIDTH(PAT_W)) u_utbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (sel_hall),
    .rdata (user_pat)
  );

  hc_pattern_sel u_sel (
    .clk          (clk),
    .rst          (rst),
    .period_end   (period_end),
    .hall_in      (hall_in),
    .hall_ovr     (hall_ovr),
    .hall_ovr_en  (hall_ovr_en),
    .use_user_tbl (use_user_tbl),
    .dflt_pat     (dflt_pat),
    .user_pat     (user_pat),
    .sel_hall     (sel_hall),
    .pat_q        (pat_q)
  );

  hc_gate_drive #(.DUTY_W(DUTY_W)) u_drv (
    .clk     (clk),
    .rst     (rst),
    .pat     (pat_q),
    .carrier (carrier),
    .duty    (duty),
    .gate_q  (gate_q)
  );

  assign gate_hi = gate_q[NUM_PH-1:0];
  assign gate_lo = gate_q[NUM_SW-1:NUM_PH];
endmodule

// File: rtl/hc_checker.sv
module hc_checker
  import hc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [HALL_W-1:0] hall_in,
  input logic [HALL_W-1:0] hall_ovr,
  input logic              hall_ovr_en,
  input logic              use_user_tbl,
  input logic              period_end,
  input logic [NUM_PH-1:0] gate_hi,
  input logic [NUM_PH-1:0] gate_lo,
  input pat_t              pat_q
);
  logic [HALL_W-1:0] chk_hall;
  logic              user_q;

  assign chk_hall = hall_ovr_en ? hall_ovr : hall_in;

  always_ff @(posedge clk) begin
    if (rst)             user_q <= 1'b0;
    else if (period_end) user_q <= use_user_tbl;
  end

  assert_reset_off_R9: assert property (@(posedge clk)
    rst |=> (gate_hi == '0 && gate_lo == '0));

  assert_hold_between_periods_R5: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(pat_q));

  assert_invalid_code_off_R1: assert property (@(posedge clk) disable iff (rst)
    (period_end && (chk_hall == '0 || chk_hall == '1)) |=> (pat_q == '0));

  // R2 and R3: the fixed table never turns on two high sides or both switches of one leg.
  assert_no_shoot_through_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(user_q) |-> ($onehot0(gate_hi) && ((gate_hi & gate_lo) == '0)));
endmodule

bind hall_commutator hc_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .hall_in      (hall_in),
  .hall_ovr     (hall_ovr),
  .hall_ovr_en  (hall_ovr_en),
  .use_user_tbl (use_user_tbl),
  .period_end   (period_end),
  .gate_hi      (gate_hi),
  .gate_lo      (gate_lo),
  .pat_q        (pat_q)
);

// File: tb/tb_hall_commutator.sv
module tb_hall_commutator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  hall_in = 3'b000;
  logic [2:0]  hall_ovr = 3'b000;
  logic        hall_ovr_en = 1'b0;
  logic        dir = 1'b0;
  logic        use_user_tbl = 1'b0;
  logic [7:0]  duty_hi = 8'd100;
  logic [2:0]  duty_lo = 3'd0;
  logic [10:0] carrier = 11'd0;
  logic        period_end = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_addr = 3'd0;
  logic [11:0] tbl_wdata = 12'd0;
  logic [2:0]  gate_hi;
  logic [2:0]  gate_lo;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [10:0] C_ON  = 11'd5;     // below duty 800
  localparam logic [10:0] C_OFF = 11'd1000;  // above duty 800

  always #4 clk = ~clk;

  hall_commutator dut (
    .clk(clk), .rst(rst), .hall_in(hall_in), .hall_ovr(hall_ovr),
    .hall_ovr_en(hall_ovr_en), .dir(dir), .use_user_tbl(use_user_tbl),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .carrier(carrier),
    .period_end(period_end), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // {dir, hall, pwm_on, expected hi (W V U), expected lo (Z Y X)}
  localparam int NV = 28;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1,3'b001,1'b1,3'b001,3'b010}, {1'b1,3'b011,1'b1,3'b100,3'b010},
    {1'b1,3'b010,1'b1,3'b100,3'b001}, {1'b1,3'b110,1'b1,3'b010,3'b001},
    {1'b1,3'b100,1'b1,3'b010,3'b100}, {1'b1,3'b101,1'b1,3'b001,3'b100},
    {1'b1,3'b001,1'b0,3'b000,3'b011}, {1'b1,3'b011,1'b0,3'b000,3'b110},
    {1'b1,3'b010,1'b0,3'b000,3'b101}, {1'b1,3'b110,1'b0,3'b000,3'b011},
    {1'b1,3'b100,1'b0,3'b000,3'b110}, {1'b1,3'b101,1'b0,3'b000,3'b101},
    {1'b0,3'b101,1'b1,3'b100,3'b001}, {1'b0,3'b100,1'b1,3'b100,3'b010},
    {1'b0,3'b110,1'b1,3'b001,3'b010}, {1'b0,3'b010,1'b1,3'b001,3'b100},
    {1'b0,3'b011,1'b1,3'b010,3'b100}, {1'b0,3'b001,1'b1,3'b010,3'b001},
    {1'b0,3'b101,1'b0,3'b000,3'b101}, {1'b0,3'b100,1'b0,3'b000,3'b110},
    {1'b0,3'b110,1'b0,3'b000,3'b011}, {1'b0,3'b010,1'b0,3'b000,3'b101},
    {1'b0,3'b011,1'b0,3'b000,3'b110}, {1'b0,3'b001,1'b0,3'b000,3'b011},
    {1'b0,3'b000,1'b1,3'b000,3'b000}, {1'b0,3'b111,1'b1,3'b000,3'b000},
    {1'b1,3'b000,1'b1,3'b000,3'b000}, {1'b1,3'b111,1'b1,3'b000,3'b000}
  };

  task automatic check(input string req, input logic [2:0] eh, input logic [2:0] el);
    n_cmp++;
    if (gate_hi !== eh || gate_lo !== el) begin
      n_bad++;
      $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b", req, gate_hi, gate_lo, eh, el);
    end
  endtask

  // Drive a code with a period-end strobe; return after the outputs reflect it.
  task automatic apply(input logic d, input logic [2:0] h, input logic [10:0] c);
    @(negedge clk);
    dir = d; hall_in = h; carrier = c; period_end = 1'b1;
    @(negedge clk);
    period_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_carrier(input logic [10:0] c);
    @(negedge clk);
    carrier = c;
    @(negedge clk);
  endtask

  task automatic write_entry(input logic [2:0] a, input logic [11:0] d, input logic we);
    @(negedge clk);
    tbl_addr = a; tbl_wdata = d; tbl_we = we;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 3'b000, 3'b000);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 no pattern before first period end", 3'b000, 3'b000);

    // Fixed table walk (R1 invalid, R2 dir=1, R3 dir=0, R4 both PWM levels)
    for (int i = 0; i < NV; i++) begin
      string tag;
      apply(VEC[i][10], VEC[i][9:7], VEC[i][6] ? C_ON : C_OFF);
      if (VEC[i][9:7] == 3'b000 || VEC[i][9:7] == 3'b111) tag = "R1";
      else if (VEC[i][10]) tag = "R2";
      else tag = "R3";
      check($sformatf("%s R4 vec%0d", tag, i), VEC[i][5:3], VEC[i][2:0]);
    end

    // R5: code change without period end is ignored
    apply(1'b1, 3'b001, C_ON);
    check("R5 base", 3'b001, 3'b010);
    @(negedge clk); hall_in = 3'b011;
    repeat (2) @(negedge clk);
    check("R5 held", 3'b001, 3'b010);
    apply(1'b1, 3'b011, C_ON);
    check("R5 boundary", 3'b100, 3'b010);

    // R4: compare edge and duty assembly, no period end
    set_carrier(11'd800);
    check("R4 equal is off", 3'b000, 3'b110);
    set_carrier(11'd799);
    check("R4 one below", 3'b100, 3'b010);
    @(negedge clk); duty_hi = 8'd1; duty_lo = 3'd3;
    set_carrier(11'd10);
    check("R4 duty 11 carrier 10", 3'b100, 3'b010);
    set_carrier(11'd11);
    check("R4 duty 11 carrier 11", 3'b000, 3'b110);
    @(negedge clk); duty_hi = 8'd100; duty_lo = 3'd0;

    // R6: override source
    @(negedge clk); hall_ovr_en = 1'b1; hall_ovr = 3'b110;
    apply(1'b1, 3'b001, C_ON);
    check("R6 override used", 3'b010, 3'b001);
    @(negedge clk); hall_ovr = 3'b000;
    apply(1'b1, 3'b001, C_ON);
    check("R6 R1 invalid override", 3'b000, 3'b000);
    @(negedge clk); hall_ovr_en = 1'b0;
    apply(1'b1, 3'b001, C_ON);
    check("R6 live pins", 3'b001, 3'b010);

    // R7 / R8: user table
    write_entry(3'd3, 12'h001, 1'b1);
    write_entry(3'd5, 12'hB00, 1'b1);
    write_entry(3'd0, 12'hFFF, 1'b1);
    @(negedge clk); use_user_tbl = 1'b1;
    apply(1'b1, 3'b011, C_ON);
    check("R7 entry3 dir1", 3'b001, 3'b000);
    apply(1'b0, 3'b011, C_ON);
    check("R7 entry3 dir0", 3'b001, 3'b000);
    apply(1'b0, 3'b101, C_ON);
    check("R7 entry5 pwm on", 3'b000, 3'b100);
    apply(1'b0, 3'b101, C_OFF);
    check("R7 entry5 pwm off", 3'b000, 3'b010);
    apply(1'b0, 3'b000, C_ON);
    check("R1 user entry0 forced off", 3'b000, 3'b000);
    write_entry(3'd3, 12'h040, 1'b0);
    apply(1'b1, 3'b011, C_ON);
    check("R8 no write without enable", 3'b001, 3'b000);
    write_entry(3'd3, 12'h040, 1'b1);
    apply(1'b1, 3'b011, C_ON);
    check("R8 rewrite", 3'b000, 3'b001);
    @(negedge clk); use_user_tbl = 1'b0;
    apply(1'b1, 3'b011, C_ON);
    check("R7 back to fixed", 3'b100, 3'b010);

    // R9: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9 reset mid-run", 3'b000, 3'b000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 pattern cleared", 3'b000, 3'b000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule